// File: doc/BRIEF.md
# Crossbar-Routed Lookup-Table Fabric

A small reconfigurable logic fabric with four 5-input lookup-table blocks arranged 2 x 2. Five crossbar matrices (left, top, right, bottom, centre) carry 5-bit bus segments between each other. Four connection matrices each pick one segment to drive the five inputs of one block. Every crossbar segment is a register, so each hop through a crossbar costs one clock cycle. Because every path passes through a register, no routing pattern can close a combinational loop.

All routing selects and table contents sit in a single 155-bit serial chain. After a global reset, the chain is loaded one bit per cycle. Once the last bit is in, the done flag rises and signals start to flow. Until then every edge output reads zero.

The four edge crossbars each take one 5-bit external input bus and present their segment as one 5-bit external output bus. The centre crossbar has no external pins.

Top module: `lutfab_top`

## Requirements
- R1: Reset (rst_n low, asynchronous) clears cfg_done and drives every edge_out bit to 0.
- R2: While cfg_en is high and cfg_done is low, one cfg_bit is taken per rising edge. cfg_done goes high on the edge that takes bit number 155 and stays high until reset. Bits offered while cfg_done is high change nothing.
- R3: The first bit shifted in ends at chain bit 154. Chain bits [154:140] are five 3-bit crossbar selects, left, top, right, bottom, centre in that order, first at the top. Bits [139:128] are four 3-bit connection selects for blocks 0 to 3. Bits [127:0] are the four 32-bit tables, block 0 in [127:96] through block 3 in [31:0]. Each field is stored MSB first.
- R4: While cfg_done is low, every edge_out bit is 0, whatever edge_in carries.
- R5: Crossbar select codes: 1 to 5 pick the segment of crossbar 0 to 4 (left=0, top=1, right=2, bottom=3, centre=4); 6 picks that crossbar's edge input (zero for the centre); 7 picks the block-output bus. The chosen value appears on the segment one cycle later. Edge slot e of edge_in/edge_out (bits 5e+4:5e) belongs to crossbar e.
- R6: A crossbar select of 0 leaves that segment at 0.
- R7: Connection select codes 1 to 5 feed a block the segment of crossbar 0 to 4. Code 0 (or 6, 7) feeds it all zeros.
- R8: A block outputs bit v of its table when its 5-bit input equals v. The block-output bus carries block k on bit k and 0 on bit 4.
- R9: One edge input bus can feed all four blocks, with all four outputs leaving through one edge crossbar, two cycles after the input.
- R10: A path through crossbars only, with the tables unused, carries an edge input to another edge after one cycle per crossbar crossed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low global reset |
| cfg_en | input | 1 | Shift enable for the configuration chain |
| cfg_bit | input | 1 | Serial configuration data |
| edge_in | input | 20 | Four 5-bit edge input buses, slot e for crossbar e |
| cfg_done | output | 1 | Configuration complete |
| edge_out | output | 20 | Four 5-bit edge output buses, slot e from crossbar e |

## Verification
The assertions assume that reset is applied at time zero and that cfg_en changes only away from the clock edge. They also assume that configuration is loaded in a single reset-then-load sequence. The stimulus holds reset from the first cycle and drives all inputs on the falling edge. It also reasserts reset before every new configuration. Edge inputs may change freely during loading, because the fabric must suppress them there.

// File: rtl/lutfab_pkg.sv
package lutfab_pkg;
    localparam int N_XBAR = 5;
    localparam int N_EDGE = 4;
    localparam int N_BLK  = 4;
    localparam int SEL_W  = 3;
    localparam logic [SEL_W-1:0] XS_OFF  = 3'd0;
    localparam logic [SEL_W-1:0] XS_EDGE = 3'd6;
    localparam logic [SEL_W-1:0] XS_LUT  = 3'd7;
endpackage

// File: rtl/lutfab_cfg_chain.sv
module lutfab_cfg_chain #(
    parameter int TOTAL = 155
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_en,
    input  logic             cfg_bit,
    output logic [TOTAL-1:0] chain,
    output logic             done
);
    localparam int CNT_W = $clog2(TOTAL + 1);

    typedef struct packed {
        logic [TOTAL-1:0] sr;
        logic [CNT_W-1:0] cnt;
        logic             done;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cfg_en && !st_q.done) begin
            st_d.sr   = {st_q.sr[TOTAL-2:0], cfg_bit};
            st_d.cnt  = st_q.cnt + CNT_W'(1);
            st_d.done = (st_q.cnt == CNT_W'(TOTAL - 1));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign chain = st_q.sr;
    assign done  = st_q.done;
endmodule

// File: rtl/lutfab_xbar.sv
module lutfab_xbar
    import lutfab_pkg::*;
#(
    parameter int W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               run,
    input  logic [SEL_W-1:0]   sel,
    input  logic [N_XBAR*W-1:0] seg_all,
    input  logic [W-1:0]       edge_in,
    input  logic [W-1:0]       lut_bus,
    output logic [W-1:0]       seg
);
    typedef struct packed {
        logic [W-1:0] seg;
    } st_t;

    st_t st_d, st_q;
    logic [W-1:0] pick;

    always_comb begin
        pick = '0;
        for (int s = 0; s < N_XBAR; s++) begin
            if (sel == SEL_W'(s + 1)) pick = seg_all[s*W +: W];
        end
        if (sel == XS_EDGE) pick = edge_in;
        if (sel == XS_LUT)  pick = lut_bus;
        st_d.seg = run ? pick : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign seg = st_q.seg;
endmodule

// File: rtl/lutfab_block.sv
module lutfab_block
    import lutfab_pkg::*;
#(
    parameter int K = 5
) (
    input  logic [SEL_W-1:0]    sel,
    input  logic [N_XBAR*K-1:0] seg_all,
    input  logic [(1<<K)-1:0]   table_bits,
    output logic                y
);
    logic [K-1:0] addr;

    always_comb begin
        addr = '0;
        for (int s = 0; s < N_XBAR; s++) begin
            if (sel == SEL_W'(s + 1)) addr = seg_all[s*K +: K];
        end
        y = table_bits[addr];
    end
endmodule

// File: rtl/lutfab_top.sv
module lutfab_top
    import lutfab_pkg::*;
#(
    parameter int W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_bit,
    input  logic [N_EDGE*W-1:0] edge_in,
    output logic              cfg_done,
    output logic [N_EDGE*W-1:0] edge_out
);
    localparam int TAB    = 1 << W;
    localparam int XS_LEN = N_XBAR * SEL_W;
    localparam int CM_LEN = N_BLK * SEL_W;
    localparam int TOTAL  = XS_LEN + CM_LEN + N_BLK * TAB;

    logic [TOTAL-1:0]    chain;
    logic [N_XBAR*W-1:0] seg_all;
    logic [N_BLK-1:0]    blk_y;
    logic [W-1:0]        lut_bus;

    lutfab_cfg_chain #(.TOTAL(TOTAL)) cfg_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .chain(chain), .done(cfg_done)
    );

    assign lut_bus = W'(blk_y);

    for (genvar x = 0; x < N_XBAR; x++) begin : g_xbar
        logic [W-1:0] ein;
        if (x < N_EDGE) begin : g_edge
            assign ein = edge_in[x*W +: W];
            assign edge_out[x*W +: W] = cfg_done ? seg_all[x*W +: W] : '0;
        end else begin : g_inner
            assign ein = '0;
        end
        lutfab_xbar #(.W(W)) xbar_i (
            .clk(clk), .rst_n(rst_n), .run(cfg_done),
            .sel(chain[TOTAL-1-x*SEL_W -: SEL_W]),
            .seg_all(seg_all), .edge_in(ein), .lut_bus(lut_bus),
            .seg(seg_all[x*W +: W])
        );
    end

    for (genvar b = 0; b < N_BLK; b++) begin : g_blk
        lutfab_block #(.K(W)) blk_i (
            .sel(chain[TOTAL-1-XS_LEN-b*SEL_W -: SEL_W]),
            .seg_all(seg_all),
            .table_bits(chain[(N_BLK-b)*TAB-1 -: TAB]),
            .y(blk_y[b])
        );
    end
endmodule

// File: rtl/lutfab_chk.sv
module lutfab_chk #(
    parameter int W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_en,
    input logic            cfg_done,
    input logic [4*W-1:0]  edge_out
);
    // R4
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |-> edge_out == '0);
    // R2
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> cfg_done);
    // R2
    done_needs_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> $past(cfg_en));
    // R2
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_done));
    // R4
    first_run_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_done) |-> edge_out == '0);
endmodule

bind lutfab_top lutfab_chk #(.W(W)) chk_i (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en),
    .cfg_done(cfg_done), .edge_out(edge_out)
);

// File: tb/lutfab_top_tb_top.sv
`timescale 1ns/1ps
module lutfab_top_tb_top;
    localparam int W = 5;
    localparam int TOTAL = 155;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic cfg_bit = 1'b0;
    logic [4*W-1:0] edge_in = '0;
    logic cfg_done;
    logic [4*W-1:0] edge_out;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    logic [2:0]  xs_t [5];
    logic [2:0]  cs_t [4];
    logic [31:0] lt_t [4];
    logic [TOTAL-1:0] bits;

    lutfab_top #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_bit(cfg_bit),
        .edge_in(edge_in), .cfg_done(cfg_done), .edge_out(edge_out)
    );

    always #2.5 clk = ~clk;

    function automatic logic [W-1:0] eo(input int e);
        return edge_out[e*W +: W];
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic clear_cfg();
        for (int i = 0; i < 5; i++) xs_t[i] = 3'd0;
        for (int i = 0; i < 4; i++) begin cs_t[i] = 3'd0; lt_t[i] = 32'h0; end
    endtask

    // R3: assemble the chain image
    task automatic build();
        bits = {xs_t[0], xs_t[1], xs_t[2], xs_t[3], xs_t[4],
                cs_t[0], cs_t[1], cs_t[2], cs_t[3],
                lt_t[0], lt_t[1], lt_t[2], lt_t[3]};
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; cfg_en = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic shift_bits(input int n);
        for (int i = 0; i < n; i++) begin
            cfg_en = 1'b1;
            cfg_bit = bits[TOTAL-1-i];
            @(negedge clk);
        end
        cfg_en = 1'b0;
    endtask

    task automatic load_full();
        build();
        shift_bits(TOTAL - 1);
        chk("R2 done before last bit", W'(cfg_done), W'(0));
        cfg_en = 1'b1; cfg_bit = bits[0];
        @(negedge clk);
        cfg_en = 1'b0;
        chk("R2 done after last bit", W'(cfg_done), W'(1));
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 done at reset", W'(cfg_done), W'(0));
        for (int e = 0; e < 4; e++) chk("R1 edge_out at reset", eo(e), '0);
    endtask

    task automatic t_partial();
        do_reset();
        clear_cfg();
        xs_t[0] = 3'd6; xs_t[1] = 3'd1; xs_t[2] = 3'd1; xs_t[3] = 3'd1;
        build();
        edge_in = {4{5'h1b}};
        shift_bits(100);
        repeat (3) @(negedge clk);
        chk("R4 done during load", W'(cfg_done), W'(0));
        for (int e = 0; e < 4; e++) chk("R4 edge_out during load", eo(e), '0);
        edge_in = '0;
    endtask

    task automatic t_path();
        do_reset();
        clear_cfg();
        // left<-edge, bottom<-left, right<-bottom, centre<-right, top<-centre
        xs_t[0] = 3'd6; xs_t[3] = 3'd1; xs_t[2] = 3'd4; xs_t[4] = 3'd3; xs_t[1] = 3'd5;
        edge_in = '0;
        load_full();
        // R2: extra bits after done must be ignored
        bits = '1;
        shift_bits(20);
        edge_in[0 +: W] = 5'h0a;
        repeat (6) @(negedge clk);
        chk("R10 path steady", eo(1), 5'h0a);
        edge_in[0 +: W] = 5'h15;
        @(negedge clk);
        chk("R5 one hop to left", eo(0), 5'h15);
        @(negedge clk);
        @(negedge clk);
        chk("R5 three hops to right", eo(2), 5'h15);
        @(negedge clk);
        chk("R10 top before fifth hop", eo(1), 5'h0a);
        @(negedge clk);
        chk("R10 top after fifth hop", eo(1), 5'h15);
        chk("R2 extra bits ignored", eo(3), 5'h15);
    endtask

    task automatic t_luts();
        logic [W-1:0] exp;
        do_reset();
        clear_cfg();
        xs_t[0] = 3'd6; xs_t[1] = 3'd7;
        for (int b = 0; b < 4; b++) cs_t[b] = 3'd1;
        lt_t[0] = 32'h0000_0020;
        lt_t[1] = 32'hFFFF_FFDF;
        lt_t[2] = 32'h6996_9669;
        lt_t[3] = 32'hAAAA_AAAA;
        load_full();
        for (int v = 0; v < 32; v++) begin
            edge_in[0 +: W] = W'(v);
            @(negedge clk);
            @(negedge clk);
            exp = {1'b0, lt_t[3][v], lt_t[2][v], lt_t[1][v], lt_t[0][v]};
            chk("R8/R9 four blocks out through top", eo(1), exp);
        end
        chk("R6 right select off", eo(2), '0);
        chk("R6 bottom select off", eo(3), '0);
    endtask

    task automatic t_cm_off();
        do_reset();
        clear_cfg();
        xs_t[0] = 3'd6; xs_t[1] = 3'd7;
        cs_t[0] = 3'd0; cs_t[1] = 3'd1;
        lt_t[0] = 32'h0000_0001;
        lt_t[1] = 32'h0000_0001;
        load_full();
        edge_in[0 +: W] = 5'h13;
        repeat (3) @(negedge clk);
        chk("R7 connection off feeds zero", eo(1), 5'h01);
        edge_in[0 +: W] = 5'h00;
        repeat (3) @(negedge clk);
        chk("R7 connection from left seg", eo(1), 5'h03);
        rst_n = 1'b0;
        #1;
        chk("R1 mid-run reset done", W'(cfg_done), W'(0));
        chk("R1 mid-run reset out", eo(1), '0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        t_reset();
        t_partial();
        t_path();
        t_luts();
        t_cm_off();
        finish_run();
    end
endmodule